// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block supervises software. Once running, it counts prescaled clock ticks. If software does not send a service strobe before the count reaches a set limit, the block raises a system reset request for a fixed number of cycles and then starts counting again from zero. A hardware fuse input makes the watchdog run straight out of power-on, with no software action needed. When the fuse is clear, a software enable input decides whether the watchdog runs.

A three-bit cause register sits alongside the timer. Each bit is a sticky flag for one reset source:

- external reset pin
- watchdog expiry
- brown-out

A flag is set by its event and survives the system reset that the event produced. Only power-on, or software writing a zero to that bit, clears it. After startup, software reads the flags to learn why the system was last reset.

The power-on reset input is asynchronous and active low. Inside the block, its release is synchronised with two flops.

Top module: `wdog_rst_cause`

## Requirements
- R1: While `por_ni` is low, `sys_rst_o` is 0 and `cause_o` is 000. After `por_ni` rises, the block starts counting on the third rising clock edge; the first two edges are spent releasing the reset synchronisation.
- R2: When `fuse_en_i` is 1, the watchdog runs whatever the value of `sw_en_i`. This includes running straight out of power-on.
- R3: When `fuse_en_i` is 0, the watchdog runs only while `sw_en_i` is 1. While it is not running, its count is held at zero and `sys_rst_o` stays low.
- R4: Timeout and clearing cycles.
  - A "clearing cycle" is any cycle in which the watchdog is stopped, `kick_i` is high, `ext_rst_i` is high or `bor_i` is high.
  - `sys_rst_o` rises exactly PRESCALE_DIV*TIMEOUT_TICKS running cycles after the last clearing cycle, provided no further clearing cycle intervenes. With the defaults this is 32 cycles.
- R5: A one-cycle `kick_i` pulse restarts the count. The next expiry then comes PRESCALE_DIV*TIMEOUT_TICKS cycles after the kick cycle.
- R6: `sys_rst_o` stays high for exactly RST_CYCLES cycles (16 by default). On the edge where it falls, the count starts again from zero.
- R7: `kick_i` pulses sent while the watchdog is stopped have no effect. After the watchdog is then enabled, the expiry still falls exactly PRESCALE_DIV*TIMEOUT_TICKS cycles later.
- R8: Once `sys_rst_o` is high, `kick_i`, the enables, `ext_rst_i` and `bor_i` do not shorten or extend the pulse.
- R9: Bit 1 of `cause_o` is set on the same edge on which `sys_rst_o` rises after an expiry. It stays set through the reset pulse and afterwards.
- R10: External pin and brown-out sources.
  - Bit 0 of `cause_o` is set on every clock edge on which `ext_rst_i` is high.
  - Bit 2 of `cause_o` is set on every clock edge on which `bor_i` is high.
  - Both inputs also act as clearing cycles for the count (see R4).
- R11: Clearing the flags by software.
  - A cycle with `cause_wr_i` high clears every flag whose bit in `cause_wdata_i` is 0.
  - Flags whose written bit is 1 are left unchanged.
  - A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Asynchronous active-low power-on reset |
| fuse_en_i | input | 1 | Hardware fuse enable; overrides the software enable |
| sw_en_i | input | 1 | Software enable, used when the fuse is clear |
| kick_i | input | 1 | Service strobe that restarts the count |
| ext_rst_i | input | 1 | External reset pin event (already synchronised) |
| bor_i | input | 1 | Brown-out event flag |
| cause_wr_i | input | 1 | Write strobe for the cause register |
| cause_wdata_i | input | 3 | Write data; a 0 bit clears the matching flag |
| sys_rst_o | output | 1 | Synchronous system reset request |
| cause_o | output | 3 | Sticky cause flags: [0] external, [1] watchdog, [2] brown-out |

## Verification
An error in the tick or timeout counters shows up only as a shift in the cycle on which `sys_rst_o` rises. The bench therefore measures the rise exactly from enable, from a kick and from external events, so an off-by-one fault appears after 32 cycles at most.

A fault in the pulse counter changes the width of the `sys_rst_o` pulse, which is visible within 16 cycles. It also shifts every timeout that follows.

Cause-flag faults appear on `cause_o` on the edge after the event or write. A cycle-level model compares both outputs every cycle through a long random run, so an error in a rarely used path is caught when that path is first exercised.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_EXT = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_BOR = 2;

  typedef enum logic {
    WD_COUNT = 1'b0,
    WD_PULSE = 1'b1
  } wdog_state_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRESCALE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (PRESCALE_DIV <= 1) begin : g_nodiv
      assign tick_o = !clr_i;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE_DIV);
      localparam logic [PW-1:0] PMAX = PW'(PRESCALE_DIV - 1);
      logic [PW-1:0] pcnt_q, pcnt_d;
      logic          at_max;

      assign at_max = (pcnt_q == PMAX);
      assign tick_o = !clr_i && at_max;

      always_comb begin
        if (clr_i || at_max) pcnt_d = '0;
        else                 pcnt_d = pcnt_q + PW'(1);
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pcnt_q <= '0;
        else         pcnt_q <= pcnt_d;
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_timeout.sv
module wdog_timeout
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 8,
  parameter int RST_CYCLES    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic kick_i,
  input  logic tick_i,
  output logic expire_o,
  output logic pulse_o
);
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam int RW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [TW-1:0] TMAX = TW'(TIMEOUT_TICKS - 1);
  localparam logic [RW-1:0] RMAX = RW'(RST_CYCLES - 1);

  wdog_state_e   state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    rcnt_d   = rcnt_q;
    expire_o = 1'b0;
    unique case (state_q)
      WD_COUNT: begin
        if (hold_i || kick_i) begin
          tcnt_d = '0;
        end else if (tick_i) begin
          if (tcnt_q == TMAX) begin
            state_d  = WD_PULSE;
            tcnt_d   = '0;
            rcnt_d   = '0;
            expire_o = 1'b1;
          end else begin
            tcnt_d = tcnt_q + TW'(1);
          end
        end
      end
      WD_PULSE: begin
        if (rcnt_q == RMAX) begin
          state_d = WD_COUNT;
          rcnt_d  = '0;
        end else begin
          rcnt_d = rcnt_q + RW'(1);
        end
      end
      default: state_d = WD_COUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_COUNT;
      tcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign pulse_o = (state_q == WD_PULSE);

  // R3
  stopped_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && hold_i) |=> !pulse_o);

  // R5
  kick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && kick_i) |=> (tcnt_q == '0));

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> ($past(rcnt_q) == RMAX));

  // R8
  pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && rcnt_q != RMAX) |=> pulse_o);
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
  import wdog_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               wr_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] flag_q, flag_d, keep;

  always_comb begin
    keep   = wr_i ? wdata_i : '1;
    flag_d = set_i | (flag_q & keep);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign cause_o = flag_q;

  // R9
  wdt_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[CAUSE_WDT] |=> cause_o[CAUSE_WDT]);

  // R11
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[CAUSE_BOR] && !set_i[CAUSE_BOR]) |=> !cause_o[CAUSE_BOR]);
endmodule

// File: rtl/wdog_rst_cause.sv
module wdog_rst_cause
  import wdog_pkg::*;
#(
  parameter int PRESCALE_DIV  = 4,
  parameter int TIMEOUT_TICKS = 8,
  parameter int RST_CYCLES    = 16
) (
  input  logic         clk_i,
  input  logic         por_ni,
  input  logic         fuse_en_i,
  input  logic         sw_en_i,
  input  logic         kick_i,
  input  logic         ext_rst_i,
  input  logic         bor_i,
  input  logic         cause_wr_i,
  input  logic [2:0]   cause_wdata_i,
  output logic         sys_rst_o,
  output logic [2:0]   cause_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n;
  logic               run, hold, tick, expire, pulse, presc_clr;
  logic [CAUSE_W-1:0] cause_set;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign run       = fuse_en_i || sw_en_i;
  assign hold      = !run || ext_rst_i || bor_i;
  assign presc_clr = hold || kick_i || pulse;

  wdog_prescale #(.PRESCALE_DIV(PRESCALE_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (presc_clr),
    .tick_o (tick)
  );

  wdog_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .RST_CYCLES(RST_CYCLES)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .hold_i   (hold),
    .kick_i   (kick_i),
    .tick_i   (tick),
    .expire_o (expire),
    .pulse_o  (pulse)
  );

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_EXT] = ext_rst_i;
    cause_set[CAUSE_WDT] = expire;
    cause_set[CAUSE_BOR] = bor_i;
  end

  wdog_cause u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .set_i   (cause_set),
    .wr_i    (cause_wr_i),
    .wdata_i (cause_wdata_i),
    .cause_o (cause_o)
  );

  assign sys_rst_o = pulse;

  // R2
  fuse_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fuse_en_i && !sw_en_i && !ext_rst_i && !bor_i && !kick_i && !pulse) |-> !hold);

  // R10
  ext_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ext_rst_i |=> cause_o[CAUSE_EXT]);

  // R1
  por_clear_chk: assert property (@(posedge clk_i)
    !por_ni |-> (cause_o == '0 && !sys_rst_o));
endmodule

// File: tb/wdog_rst_cause_tb_top.sv
module wdog_rst_cause_tb_top;
  localparam int DIV  = 4;
  localparam int TT   = 8;
  localparam int RC   = 16;
  localparam int TOUT = DIV * TT;

  logic       clk_i = 1'b0;
  logic       por_ni = 1'b0;
  logic       fuse_en_i = 1'b0, sw_en_i = 1'b0, kick_i = 1'b0;
  logic       ext_rst_i = 1'b0, bor_i = 1'b0, cause_wr_i = 1'b0;
  logic [2:0] cause_wdata_i = 3'b111;
  logic       sys_rst_o;
  logic [2:0] cause_o;

  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  wdog_rst_cause #(.PRESCALE_DIV(DIV), .TIMEOUT_TICKS(TT), .RST_CYCLES(RC)) dut_i (
    .clk_i(clk_i), .por_ni(por_ni), .fuse_en_i(fuse_en_i), .sw_en_i(sw_en_i),
    .kick_i(kick_i), .ext_rst_i(ext_rst_i), .bor_i(bor_i), .cause_wr_i(cause_wr_i),
    .cause_wdata_i(cause_wdata_i), .sys_rst_o(sys_rst_o), .cause_o(cause_o)
  );

  // cycle-level reference built from the requirements
  int       m_sync, m_el, m_pc;
  bit       m_pulse;
  bit [2:0] m_cause;

  always @(posedge clk_i or negedge por_ni) begin
    bit hold, ev;
    if (!por_ni) begin
      m_sync = 0; m_el = 0; m_pc = 0; m_pulse = 0; m_cause = 3'b000;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      hold = !(fuse_en_i || sw_en_i) || ext_rst_i || bor_i;
      ev = 0;
      if (m_pulse) begin
        if (m_pc == RC - 1) begin m_pulse = 0; m_el = 0; end
        else m_pc++;
      end else if (hold || kick_i) m_el = 0;
      else if (m_el == TOUT - 1) begin m_pulse = 1; m_pc = 0; m_el = 0; ev = 1; end
      else m_el++;
      if (cause_wr_i) m_cause = m_cause & cause_wdata_i;
      m_cause = m_cause | {bor_i, ev, ext_rst_i};
    end
  end

  always @(negedge clk_i) begin
    n_chk++;
    if (sys_rst_o !== m_pulse || cause_o !== m_cause) begin
      n_bad++;
      $display("FAIL R4 R6 R9 R10 R11 model: sys_rst %b exp %b, cause %b exp %b",
               sys_rst_o, m_pulse, cause_o, m_cause);
    end
  end

  function automatic bit chk_int(string req, int act, int exp);
    return act == exp;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (!chk_int(req, act, exp)) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic measure_rise(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!sys_rst_o && n < 1000);
  endtask

  task automatic measure_len(input bit kick_mid, output int n);
    n = 1;
    forever begin
      @(negedge clk_i);
      kick_i = kick_mid && (n > 3 && n < 8);
      if (!sys_rst_o) break;
      n++;
    end
    kick_i = 1'b0;
  endtask

  int  r;
  bit  seen;

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    fuse_en_i = 1'b1;
    wait_n(3);
    check("R1 sys_rst in reset", sys_rst_o, 0);
    check("R1 cause in reset", cause_o, 0);
    por_ni = 1'b1;
    // R2 fuse runs out of reset: 2 sync edges + timeout
    measure_rise(r);
    check("R2 fuse expiry from power-on", r, TOUT + 2);
    check("R9 wdt flag on expiry", cause_o, 3'b010);
    // R8 kicks inside pulse ignored; R6 length
    measure_len(1'b1, r);
    check("R6 R8 pulse length", r, RC);
    check("R9 wdt flag survives pulse", cause_o, 3'b010);
    // R5 kick restarts
    wait_n(20);
    kick_i = 1'b1; @(negedge clk_i); kick_i = 1'b0;
    r = 1;
    while (!sys_rst_o) begin @(negedge clk_i); r++; end
    check("R5 expiry after kick", r, TOUT + 1);
    measure_len(1'b0, r);
    check("R6 pulse length", r, RC);
    // R11 writes
    cause_wr_i = 1'b1; cause_wdata_i = 3'b111; @(negedge clk_i);
    cause_wr_i = 1'b0;
    check("R11 write ones keeps", cause_o, 3'b010);
    cause_wr_i = 1'b1; cause_wdata_i = 3'b101; @(negedge clk_i);
    cause_wr_i = 1'b0; cause_wdata_i = 3'b111;
    check("R11 write zero clears", cause_o, 3'b000);
    // R3 fuse clear, software off: nothing happens
    fuse_en_i = 1'b0; sw_en_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      kick_i = (i % 7 == 0);   // R7 kicks while stopped
      if (sys_rst_o) seen = 1;
    end
    kick_i = 1'b0;
    check("R3 no reset while stopped", seen, 0);
    sw_en_i = 1'b1;
    measure_rise(r);
    check("R3 R7 expiry after software enable", r, TOUT);
    measure_len(1'b0, r);
    // R10 external pin and brown-out
    wait_n(10);
    ext_rst_i = 1'b1; @(negedge clk_i); ext_rst_i = 1'b0;
    check("R10 ext flag", cause_o[0], 1);
    r = 1;
    while (!sys_rst_o) begin @(negedge clk_i); r++; end
    check("R10 ext clears count", r, TOUT + 1);
    measure_len(1'b0, r);
    wait_n(5);
    bor_i = 1'b1; cause_wr_i = 1'b1; cause_wdata_i = 3'b000; @(negedge clk_i);
    bor_i = 1'b0; cause_wr_i = 1'b0; cause_wdata_i = 3'b111;
    check("R10 R11 bor set beats clear", cause_o, 3'b100);
    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 500 == 0) fuse_en_i = ($urandom_range(3) == 0);
      if (c % 200 == 0) sw_en_i = ($urandom_range(3) != 0);
      kick_i     = ($urandom_range(39) == 0);
      ext_rst_i  = ($urandom_range(299) == 0);
      bor_i      = ($urandom_range(399) == 0);
      cause_wr_i = ($urandom_range(49) == 0);
      cause_wdata_i = 3'($urandom_range(7));
      @(negedge clk_i);
    end
    kick_i = 0; ext_rst_i = 0; bor_i = 0; cause_wr_i = 0;
    // R1 power-on clears everything again
    por_ni = 1'b0; #1;
    check("R1 por clears cause", cause_o, 0);
    check("R1 por clears sys_rst", sys_rst_o, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule